// File: doc/BRIEF.md
# Overlapping 010 / 1001 Serial Pattern Detector

This block watches a serial bit stream, one bit per clock on `x_i`, and flags on `z_o` every cycle whose bit completes a stream ending in `010` or in `1001`. The flag is a Mealy output: it depends on the current input bit and the stored history, so it is valid in the same cycle as the completing bit. Detection overlaps. A pattern that has just finished can supply the opening bits of the next one, and the machine never returns to its start state on a hit.

History is kept as six suffix classes in a 3-bit state register. The classes are: start, a trailing 0 that is not part of `10`, a trailing `01`, a trailing `10`, a trailing 1 that is not part of `01`, and a trailing `100`. The reset input is asynchronous and active low. Its release is synchronised inside the block by a two-stage synchroniser, so the machine leaves its start state only on the third rising edge after `rst_n` goes high.

Top module: `dualpat_detector`

## Requirements
- R1: While `rst_n` is low, `z_o` is 0 whatever the value of `x_i`.
- R2: After reset, the bit stream 0,1,0 drives `z_o` to 1 during the cycle that presents the final 0.
- R3: After reset, the bit stream 1,0,0,1 drives `z_o` to 1 during the cycle that presents the final 1.
- R4: `z_o` is 1 exactly when the bits taken since reset, including the current one, end in `010` or `1001`. In every other cycle it is 0.
- R5: Overlap on the short pattern. The stream 0,1,0,1,0 raises `z_o` on bit 3 and on bit 5.
- R6: Overlap across the two patterns. The stream 1,0,0,1,0 raises `z_o` on bit 4 and bit 5, and the stream 1,0,0,1,0,0,1 raises it on bits 4, 5 and 7.
- R7: Asserting reset discards the history. After 0,1 then a reset, a lone 0 does not raise `z_o`.
- R8: The bits presented during the first two rising edges after `rst_n` rises are not taken into history, and `z_o` stays 0 for them. The third edge takes the first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one stream bit is taken per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| x_i | input | 1 | Serial stream bit |
| z_o | output | 1 | Detection flag, combinational from the state and `x_i` |

## Verification
`z_o` is due in the same cycle as the bit that completes a pattern, with no register delay. The bench therefore sets `x_i` on the falling edge and samples `z_o` one time unit later, before the rising edge that takes the bit. After `rst_n` rises, the first two bits are expected to be ignored and the third edge is the first one that counts. Each scenario task sends these two filler bits before its pattern. A shift-register model built from the rule in R4 gives the expected flag for every bit of a long random stream.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  localparam int STATE_W = 3;

  // suffix classes of the input history
  typedef enum logic [STATE_W-1:0] {
    ST_START = 3'd0,  // nothing taken since reset
    ST_ZERO  = 3'd1,  // ends in 0, not in 10
    ST_ZO    = 3'd2,  // ends in 01
    ST_OZ    = 3'd3,  // ends in 10
    ST_ONE   = 3'd4,  // ends in 1, not in 01
    ST_OZZ   = 3'd5   // ends in 100
  } sq_state_t;
endpackage

// File: rtl/seqdet_rst_sync.sv
module seqdet_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign core_rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
(
  input  sq_state_t cur_i,
  input  logic      bit_i,
  output sq_state_t nxt_o,
  output logic      hit_o
);
  always_comb begin
    nxt_o = ST_START;
    hit_o = 1'b0;
    unique case (cur_i)
      ST_START: nxt_o = bit_i ? ST_ONE : ST_ZERO;
      ST_ZERO:  nxt_o = bit_i ? ST_ZO  : ST_ZERO;
      ST_ZO: begin
        nxt_o = bit_i ? ST_ONE : ST_OZ;
        hit_o = !bit_i;
      end
      ST_OZ:    nxt_o = bit_i ? ST_ZO  : ST_OZZ;
      ST_ONE:   nxt_o = bit_i ? ST_ONE : ST_OZ;
      ST_OZZ: begin
        nxt_o = bit_i ? ST_ZO  : ST_ZERO;
        hit_o = bit_i;
      end
      default: begin
        nxt_o = ST_START;
        hit_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
  import seqdet_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      core_rst_n,
  input  sq_state_t nxt_i,
  output sq_state_t cur_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_o <= ST_START;
    end else if (!core_rst_n) begin
      cur_o <= ST_START;
    end else begin
      cur_o <= nxt_i;
    end
  end

  // R7
  sync_hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |=> cur_o == ST_START);
endmodule

// File: rtl/dualpat_detector.sv
module dualpat_detector
  import seqdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x_i,
  output logic z_o
);
  logic      core_rst_n;
  sq_state_t cur_st;
  sq_state_t nxt_st;
  logic      hit_raw;

  seqdet_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  seqdet_next u_next (
    .cur_i (cur_st),
    .bit_i (x_i),
    .nxt_o (nxt_st),
    .hit_o (hit_raw)
  );

  seqdet_state_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n),
    .nxt_i      (nxt_st),
    .cur_o      (cur_st)
  );

  assign z_o = hit_raw & core_rst_n;

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!z_o);
    end
  end

  // R2
  hit010_keeps10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z_o && !x_i) |=> cur_st == ST_OZ);

  // R3
  hit1001_keeps01_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z_o && x_i) |=> cur_st == ST_ZO);

  // R4
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_st inside {ST_START, ST_ZERO, ST_ZO, ST_OZ, ST_ONE, ST_OZZ});
endmodule

// File: tb/dualpat_detector_test.sv
module dualpat_detector_test;
  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;
  logic x;
  logic z;
  int   n_run;
  int   n_fail;
  logic [3:0] hist;
  int   taken;

  dualpat_detector uut (.clk(clk), .rst_n(rst_n), .x_i(x), .z_o(z));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: z_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic model_z(input logic b);
    logic [3:0] h;
    h = {hist[2:0], b};
    return (taken >= 2 && h[2:0] == 3'b010) || (taken >= 3 && h == 4'b1001);
  endfunction

  // one counted bit: drive, compare with model, let the edge take it
  task automatic send(input string req, input logic b);
    @(negedge clk);
    x = b;
    #1;
    check(req, z, model_z(b));
    hist = {hist[2:0], b};
    taken++;
  endtask

  // pattern with explicit expected flag per bit (LSB first)
  task automatic send_seq(input string req, input int len, input logic [7:0] bits,
                          input logic [7:0] flags);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      x = bits[i];
      #1;
      check(req, z, flags[i]);
      check(req, z, model_z(bits[i]));
      hist = {hist[2:0], bits[i]};
      taken++;
    end
  endtask

  // reset pulse; the two fillers go in while the synchroniser releases
  task automatic do_reset(input logic f0, input logic f1);
    @(negedge clk);
    rst_n = 1'b0;
    x = 1'b1;
    #1;
    check("R1", z, 1'b0);
    @(negedge clk);
    x = 1'b0;
    #1;
    check("R1", z, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    x = f0;
    #1;
    check("R8", z, 1'b0);
    @(negedge clk);
    x = f1;
    #1;
    check("R8", z, 1'b0);
    hist = '0;
    taken = 0;
  endtask

  task automatic t_basic;
    do_reset(1'b0, 1'b0);
    send_seq("R2", 3, 8'b010, 8'b100);
    do_reset(1'b0, 1'b0);
    send_seq("R3", 4, 8'b1001, 8'b1000);
  endtask

  task automatic t_overlap;
    do_reset(1'b1, 1'b1);
    send_seq("R5", 5, 8'b01010, 8'b10100);
    do_reset(1'b0, 1'b0);
    send_seq("R6", 5, 8'b01001, 8'b11000);
    do_reset(1'b0, 1'b0);
    send_seq("R6", 7, 8'b1001001, 8'b1011000);
  endtask

  task automatic t_reset_history;
    do_reset(1'b0, 1'b0);
    send_seq("R7", 2, 8'b10, 8'b00);
    do_reset(1'b0, 1'b0);
    send_seq("R7", 1, 8'b0, 8'b0);
  endtask

  task automatic t_fillers;
    // fillers 0,1 then a 0: only "0" counts, no hit; then 1,0 completes 010
    do_reset(1'b0, 1'b1);
    send_seq("R8", 3, 8'b010, 8'b100);
  endtask

  task automatic t_random;
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 2000; i++) begin
      send("R4", 1'($urandom_range(0, 1)));
    end
  endtask

  initial begin
    n_run = 0;
    n_fail = 0;
    hist = '0;
    taken = 0;
    x = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    t_basic();
    t_overlap();
    t_reset_history();
    t_fillers();
    t_random();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule